// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a simple register bus. A free-running count climbs while counting is enabled. When it meets a programmed limit, a sticky expiry flag is raised. If a second, separate enable is also set, a system reset pulse of fixed length is driven out. The clock source and the chip-wide reset distribution sit outside the block.

The limit, control and status registers are guarded against stray writes. A write to any of them lands only if it comes straight after two key writes: the value 0xBABA to the first key register, then 0xEB10 to the second key register. Each two-key sequence opens the guard for one write only. Software therefore repeats both keys before every guarded write. The count can be read at any time without unlocking.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the limit register reads all ones (0xFFFF with a 16-bit count) and the control, status and count registers read 0. The reset output is low.
- R2: The register map is as follows. Address 0 is the first key register and address 1 the second key register. Address 2 holds the limit, address 3 the control, address 4 the status, and address 5 the count, which is read-only. Writing 0xBABA to address 0 and then 0xEB10 to address 1, on consecutive writes, opens the guard. The next write to address 2, 3 or 4 then takes effect.
- R3: A write to address 2, 3 or 4 with no unlock before it leaves that register unchanged.
- R4: An unlock permits exactly one guarded write. A second guarded write after it, with no new key pair, is ignored.
- R5: The sequence breaks on a wrong key value, on the keys in the wrong order, or on any other write between the keys. The guarded write that follows is then ignored.
- R6: The count rises by one per cycle while control bit 0 is 1 and the status flag is clear. It holds its value while control bit 0 is 0. It reads at address 5 with no unlock.
- R7: When the count equals the limit while control bit 0 is 1, status bit 0 is set on the next clock edge, and from then on the count stops. With limit M, counting enabled at edge E0, and the count starting at 0, the flag rises at edge E0+M+1.
- R8: When the flag rises while control bit 1 is 1, the reset output is high for exactly RST_LEN cycles (4 by default), starting in the same cycle as the flag. If control bit 1 is 0, the reset output stays low.
- R9: An unlocked write to status with data bit 0 equal to 0 clears the flag and restarts the count from 0. An unlocked write with data bit 0 equal to 1 changes neither the flag nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst_o | output | 1 | System reset pulse request |

## Verification
The bench first attacks the guard, checking each way it could give way. It tries a guarded write with no keys, a second write on one unlock, a wrong first key, swapped keys, and an unrelated write between the keys. A design that left the guard open for more than one write, or that remembered a half-finished sequence, would let the limit change. The bench then samples the count on every cycle up to expiry, so an off-by-one compare or a count that keeps running after expiry shows up as a wrong value. It measures the reset pulse length cycle by cycle, with the reset enable both clear and set. It also checks that writing 1 to status leaves the flag alone, while writing 0 clears the flag and restarts the count.

// File: rtl/wdk_pkg.sv
// Shared constants for the key-protected watchdog: register addresses,
// unlock key values and the unlock state encoding.
package wdk_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_KEY1  = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY2  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIMIT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

    localparam logic [31:0] KEY1_VAL = 32'h0000_BABA;
    localparam logic [31:0] KEY2_VAL = 32'h0000_EB10;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } lock_st_e;

endpackage

// File: rtl/wdk_unlock.sv
// Unlock sequencer. Tracks the two-key sequence and emits a one-cycle
// guarded-write strobe for the single write that follows a full unlock.
// Assumes at most one bus write per cycle and DW >= 32.
module wdk_unlock
    import wdk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic              prot_we
);

    lock_st_e st_q, st_d;
    logic     is_prot, key1_hit, key2_hit;

    // Decode the current write against the keys and the guarded range.
    always_comb begin
        is_prot  = (bus_addr == A_LIMIT) || (bus_addr == A_CTRL) || (bus_addr == A_STAT);
        key1_hit = (bus_addr == A_KEY1) && (bus_wdata == DW'(KEY1_VAL));
        key2_hit = (bus_addr == A_KEY2) && (bus_wdata == DW'(KEY2_VAL));
        prot_we  = bus_wr && (st_q == ST_OPEN) && is_prot;
    end

    // Next state: a correct first key restarts, anything unexpected relocks.
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (key1_hit)                        st_d = ST_HALF;
            else if (st_q == ST_HALF && key2_hit) st_d = ST_OPEN;
            else                                 st_d = ST_LOCKED;
        end
    end

    // Unlock state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOCKED;
        else        st_q <= st_d;
    end

    // R2
    open_after_key2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_OPEN) |-> ($past(bus_wr) && $past(bus_addr) == A_KEY2));

    // R4
    one_write_per_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_we |=> (st_q != ST_OPEN));

    // R5
    broken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && st_q == ST_HALF && !key2_hit) |=> (st_q != ST_OPEN));

endmodule

// File: rtl/wdk_regs.sv
// Guarded register file: limit and control storage, plus the status-clear
// strobe. Only updates on the guarded-write strobe from the sequencer.
// Assumes CNT_W >= 2.
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  limit_q,
    output logic              cnt_en_q,
    output logic              rst_en_q,
    output logic              stat_clr
);

    // Status clear fires on an unlocked status write with data bit 0 low.
    always_comb begin
        stat_clr = prot_we && (bus_addr == A_STAT) && !wdata[0];
    end

    // Limit and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q  <= '1;
            cnt_en_q <= 1'b0;
            rst_en_q <= 1'b0;
        end else if (prot_we) begin
            if (bus_addr == A_LIMIT) limit_q <= wdata;
            if (bus_addr == A_CTRL) begin
                cnt_en_q <= wdata[0];
                rst_en_q <= wdata[1];
            end
        end
    end

    // R3
    limit_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_we |=> $stable(limit_q));

    // R3
    ctrl_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_we |=> ($stable(cnt_en_q) && $stable(rst_en_q)));

endmodule

// File: rtl/wdk_core.sv
// Watchdog core: counter, sticky expiry flag and fixed-length reset pulse.
// Assumes RST_LEN >= 1; a clear has priority over counting and expiry.
module wdk_core #(
    parameter int CNT_W   = 16,
    parameter int RST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] limit,
    input  logic             stat_clr,
    output logic [CNT_W-1:0] count_q,
    output logic             flag_q,
    output logic             sys_rst_o
);

    localparam int RW = $clog2(RST_LEN + 1);

    logic [RW-1:0] pulse_q;
    logic          fire;

    // Expiry condition for this cycle.
    always_comb begin
        fire = cnt_en && !flag_q && (count_q == limit) && !stat_clr;
    end

    // Counter and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || stat_clr) begin
            count_q <= '0;
            flag_q  <= 1'b0;
        end else if (fire) begin
            flag_q  <= 1'b1;
        end else if (cnt_en && !flag_q) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Reset pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                pulse_q <= '0;
        else if (fire && rst_en)   pulse_q <= RW'(RST_LEN);
        else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
    end

    assign sys_rst_o = (pulse_q != '0);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !stat_clr) |=> $stable(count_q));

    // R7
    flag_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(count_q) == $past(limit) && $past(cnt_en)));

    // R8
    rst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($rose(flag_q) && $past(rst_en)));

    // R9
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (count_q == '0 && !flag_q));

endmodule

// File: rtl/keyed_watchdog.sv
// Top level of the key-protected watchdog. Connects the unlock sequencer,
// guarded registers and counter core, and muxes read data by address.
// Assumes DW >= 32 and 2 <= CNT_W <= DW.
module keyed_watchdog
    import wdk_pkg::*;
#(
    parameter int DW      = 32,
    parameter int CNT_W   = 16,
    parameter int RST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              sys_rst_o
);

    logic             prot_we, cnt_en, rst_en, stat_clr, flag;
    logic [CNT_W-1:0] limit, count;

    wdk_unlock #(.DW(DW)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .prot_we   (prot_we)
    );

    wdk_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_we  (prot_we),
        .bus_addr (bus_addr),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .limit_q  (limit),
        .cnt_en_q (cnt_en),
        .rst_en_q (rst_en),
        .stat_clr (stat_clr)
    );

    wdk_core #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .rst_en    (rst_en),
        .limit     (limit),
        .stat_clr  (stat_clr),
        .count_q   (count),
        .flag_q    (flag),
        .sys_rst_o (sys_rst_o)
    );

    // Read mux: key registers read as zero.
    always_comb begin
        case (bus_addr)
            A_LIMIT: bus_rdata = DW'(limit);
            A_CTRL:  bus_rdata = DW'({rst_en, cnt_en});
            A_STAT:  bus_rdata = DW'(flag);
            A_COUNT: bus_rdata = DW'(count);
            default: bus_rdata = '0;
        endcase
    end

    // R8
    rst_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> flag || $past(stat_clr));

endmodule

// File: tb/keyed_watchdog_bench.sv
// Scoreboard bench: driver tasks queue expected read data and reset level,
// a monitor pops and compares them mid-way through the low clock phase.
module keyed_watchdog_bench;

    localparam int DW = 32;

    typedef struct {
        int          kind;   // 0 = read data, 1 = reset pin
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          sys_rst_o;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sys_rst_o (sys_rst_o)
    );

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic unlock();
        wr(3'd0, 32'h0000_BABA);
        wr(3'd1, 32'h0000_EB10);
    endtask

    task automatic chk(input logic [2:0] a, input logic [31:0] e,
                       input logic r, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag; q.push_back(it);
        it.kind = 1; it.exp = {31'd0, r};       q.push_back(it);
    endtask

    // Monitor: compare every queued item in the middle of the low phase.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = (it.kind == 0) ? bus_rdata : {31'd0, sys_rst_o};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual %h expected %h", it.tag,
                             (it.kind == 0) ? "rdata" : "sys_rst", act, it.exp);
                end
            end
        end
    end

    // Watchdog on the bench itself.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk(3'd2, 32'h0000_FFFF, 1'b0, "R1 limit");
        chk(3'd3, 32'h0, 1'b0, "R1 ctrl");
        chk(3'd4, 32'h0, 1'b0, "R1 status");
        chk(3'd5, 32'h0, 1'b0, "R1 count");

        // R3 guarded write without unlock
        wr(3'd2, 32'd5);
        chk(3'd2, 32'h0000_FFFF, 1'b0, "R3 no unlock");

        // R2 full unlock then one write
        unlock();
        wr(3'd2, 32'd5);
        chk(3'd2, 32'd5, 1'b0, "R2 unlocked write");

        // R4 second write on the same unlock
        wr(3'd2, 32'd7);
        chk(3'd2, 32'd5, 1'b0, "R4 second write");

        // R5 wrong first key
        wr(3'd0, 32'h0000_1234);
        wr(3'd1, 32'h0000_EB10);
        wr(3'd2, 32'd9);
        chk(3'd2, 32'd5, 1'b0, "R5 wrong key");
        // R5 keys in swapped order
        wr(3'd1, 32'h0000_EB10);
        wr(3'd0, 32'h0000_BABA);
        wr(3'd2, 32'd9);
        chk(3'd2, 32'd5, 1'b0, "R5 swapped keys");
        // R5 intervening write
        wr(3'd0, 32'h0000_BABA);
        wr(3'd5, 32'h0);
        wr(3'd1, 32'h0000_EB10);
        wr(3'd2, 32'd9);
        chk(3'd2, 32'd5, 1'b0, "R5 intervening write");

        // R6 count holds while disabled
        chk(3'd5, 32'd0, 1'b0, "R6 hold");
        chk(3'd5, 32'd0, 1'b0, "R6 hold");

        // R6/R7 count to limit 5 with reset disabled (R8 no pulse)
        unlock();
        wr(3'd3, 32'd1);
        for (int i = 0; i < 6; i++) chk(3'd5, i, 1'b0, "R6 counting");
        chk(3'd4, 32'd1, 1'b0, "R7 flag at limit / R8 no reset");
        chk(3'd5, 32'd5, 1'b0, "R7 count stops");
        chk(3'd5, 32'd5, 1'b0, "R8 no reset when bit1 clear");

        // R9 write 1 to status has no effect
        unlock();
        wr(3'd4, 32'd1);
        chk(3'd4, 32'd1, 1'b0, "R9 write one keeps flag");
        chk(3'd5, 32'd5, 1'b0, "R9 write one keeps count");

        // R9 disable, then clear: count restarts at 0 and holds
        unlock();
        wr(3'd3, 32'd0);
        unlock();
        wr(3'd4, 32'd0);
        chk(3'd5, 32'd0, 1'b0, "R9 count cleared");
        chk(3'd4, 32'd0, 1'b0, "R9 flag cleared");
        chk(3'd5, 32'd0, 1'b0, "R6 hold after clear");

        // R8 both enables: pulse of 4 cycles starting with the flag
        unlock();
        wr(3'd3, 32'd3);
        chk(3'd3, 32'd3, 1'b0, "R2 ctrl written");
        for (int i = 1; i < 6; i++) chk(3'd5, i, 1'b0, "R7 counting");
        chk(3'd4, 32'd1, 1'b1, "R8 pulse start");
        for (int i = 0; i < 3; i++) chk(3'd5, 32'd5, 1'b1, "R8 pulse held");
        chk(3'd5, 32'd5, 1'b0, "R8 pulse end");
        chk(3'd4, 32'd1, 1'b0, "R8 stays low");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule